// File: doc/BRIEF.md
# Oversampling Ratio Detector and Bit-Clock Divider

This block sits in the master-clock domain of an audio serial receiver. It measures the length of each word-select period in master-clock cycles, sorts that length into one of three supported oversampling ratios (256, 384 or 512 master clocks per sample), and reports a ratio code once two successive periods agree. While locked, it divides the master clock down to a single-cycle bit-clock enable: 32 enables per sample for the 256 and 512 ratios and 48 for the 384 ratio. It also reports the longest data word that the chosen bit-clock rate can carry.

A mode input tells the block that the serial bit clock comes from outside. In that mode the internal enable stays low and the word limit is always 24 bits. Ratio detection, the lock flag and the invalid flag keep working in either mode. Word-select, the master clock and the data path are assumed to be synchronous, so word-select is sampled directly.

Top module: `osr_clock_detect`

## Requirements
- R1: A period is the number of master-clock cycles from one sampled rising edge of `ws` to the next. The first rising edge after reset only starts counting and produces no measurement, so it neither sets `invalid` nor becomes a lock candidate.
- R2: A measurement within plus or minus TOL (default 2) cycles of 256, 384 or 512 is classified as that ratio. `ratio_code` shows the locked ratio with 1 = 256, 2 = 384, 3 = 512, and shows 0 whenever `locked` is low.
- R3: `invalid` goes high after a measurement that falls outside all three windows. The next in-window measurement clears it.
- R4: From the unlocked state, `locked` rises only after two consecutive measurements in the same ratio window.
- R5: While locked, one measurement that differs from the locked ratio is tolerated if the next one matches. Two consecutive differing measurements drop `locked`, set `ratio_code` to 0 and clear the candidate, so two new matching measurements are needed before lock returns.
- R6: While locked with `ext_bclk` low, `bclk_en` is a one-cycle pulse every 8 master clocks for ratios 256 and 384 and every 16 for ratio 512. The divider phase restarts at each `ws` transition. This gives 32, 48 and 32 pulses per word-select period respectively. While unlocked, `bclk_en` stays low.
- R7: `word_bits` is 24 when `ext_bclk` is high, 24 when locked at ratio 384, 16 when locked at ratio 256 or 512, and 0 otherwise. It follows its inputs one cycle later.
- R8: The period counter saturates at 2^CNT_W-1 (2047 by default) and does not wrap. A 2304-cycle period is therefore reported as invalid and not as ratio 256.
- R9: With `ext_bclk` high, `bclk_en` is held low while detection, `locked`, `invalid` and `ratio_code` behave as in internal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| ws | input | 1 | Word-select, synchronous to clk |
| ext_bclk | input | 1 | High: bit clock is supplied from outside |
| bclk_en | output | 1 | Internal bit-clock enable pulse |
| ratio_code | output | 2 | Locked ratio: 0 none, 1 = 256, 2 = 384, 3 = 512 |
| locked | output | 1 | Ratio lock established |
| invalid | output | 1 | Last measurement matched no supported ratio |
| word_bits | output | 5 | Maximum word length allowed: 0, 16 or 24 |

## Verification
Losing lock and flagging an invalid period can happen on the same clock edge. This occurs when the second of two out-of-window periods arrives while the block is locked. The bench locks at ratio 256 and then sends two 300-cycle periods. It samples the flags every cycle and records the value of `invalid` in the exact cycle in which `locked` falls, expecting it to be high. It also checks that the first bad period alone raised `invalid` while `locked` stayed high.

// File: rtl/osr_pkg.sv
`timescale 1ns/1ps
package osr_pkg;

  typedef enum logic [1:0] {
    RATIO_NONE = 2'd0,
    RATIO_256  = 2'd1,
    RATIO_384  = 2'd2,
    RATIO_512  = 2'd3
  } ratio_e;

  localparam logic [4:0] WORD_NONE  = 5'd0;
  localparam logic [4:0] WORD_SHORT = 5'd16;
  localparam logic [4:0] WORD_LONG  = 5'd24;

  // master clocks per sample for each ratio code
  function automatic int nominal_of(int idx);
    case (idx)
      1:       return 256;
      2:       return 384;
      3:       return 512;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/osr_ws_meter.sv
`timescale 1ns/1ps
module osr_ws_meter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ws,
  output logic             ws_toggle,
  output logic [CNT_W-1:0] period,
  output logic             period_vld
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             ws_q;
  logic             seen_edge;
  logic [CNT_W-1:0] cnt;
  logic             ws_rise;

  assign ws_rise   = ws & ~ws_q;
  assign ws_toggle = ws ^ ws_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_q       <= 1'b0;
      seen_edge  <= 1'b0;
      cnt        <= '0;
      period     <= '0;
      period_vld <= 1'b0;
    end else begin
      ws_q       <= ws;
      period_vld <= 1'b0;
      if (ws_rise) begin
        cnt       <= CNT_ONE;
        seen_edge <= 1'b1;
        if (seen_edge) begin
          period     <= cnt;
          period_vld <= 1'b1;
        end
      end else if (cnt != CNT_MAX) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/osr_ratio_classifier.sv
`timescale 1ns/1ps
module osr_ratio_classifier
  import osr_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int TOL   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period,
  input  logic             period_vld,
  output ratio_e           cls,
  output logic             cls_vld
);

  logic [3:1] in_window;
  ratio_e     hit;

  for (genvar g = 1; g < 4; g++) begin : g_window
    localparam int NOM = nominal_of(g);
    assign in_window[g] = (int'(period) >= NOM - TOL) && (int'(period) <= NOM + TOL);
  end

  always_comb begin
    if (in_window[3])      hit = RATIO_512;
    else if (in_window[2]) hit = RATIO_384;
    else if (in_window[1]) hit = RATIO_256;
    else                   hit = RATIO_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cls     <= RATIO_NONE;
      cls_vld <= 1'b0;
    end else begin
      cls_vld <= period_vld;
      if (period_vld) cls <= hit;
    end
  end

endmodule

// File: rtl/osr_lock_fsm.sv
`timescale 1ns/1ps
module osr_lock_fsm
  import osr_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  ratio_e cls,
  input  logic   cls_vld,
  output logic   locked,
  output logic   invalid,
  output ratio_e lock_ratio
);

  ratio_e cand;
  logic   cand_vld;
  logic   miss;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked     <= 1'b0;
      invalid    <= 1'b0;
      lock_ratio <= RATIO_NONE;
      cand       <= RATIO_NONE;
      cand_vld   <= 1'b0;
      miss       <= 1'b0;
    end else if (cls_vld) begin
      invalid <= (cls == RATIO_NONE);
      if (!locked) begin
        if (cand_vld && cls == cand) begin
          locked     <= 1'b1;
          lock_ratio <= cls;
          miss       <= 1'b0;
        end else begin
          cand     <= cls;
          cand_vld <= (cls != RATIO_NONE);
        end
      end else if (cls == lock_ratio) begin
        miss <= 1'b0;
      end else if (miss) begin
        locked     <= 1'b0;
        lock_ratio <= RATIO_NONE;
        cand       <= RATIO_NONE;
        cand_vld   <= 1'b0;
        miss       <= 1'b0;
      end else begin
        miss <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/osr_bclk_div.sv
`timescale 1ns/1ps
module osr_bclk_div #(
  parameter int DIV_NARROW = 8,
  parameter int DIV_WIDE   = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic ws_toggle,
  input  logic run,
  input  logic wide,
  output logic bclk_en
);

  localparam int CW = $clog2(DIV_WIDE);

  logic [CW-1:0] phase;
  logic [CW-1:0] last;

  assign last = wide ? CW'(DIV_WIDE - 1) : CW'(DIV_NARROW - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= '0;
      bclk_en <= 1'b0;
    end else begin
      bclk_en <= run && (phase == last);
      if (ws_toggle || phase == last) phase <= '0;
      else                            phase <= phase + 1'b1;
    end
  end

endmodule

// File: rtl/osr_clock_detect.sv
`timescale 1ns/1ps
module osr_clock_detect
  import osr_pkg::*;
#(
  parameter int CNT_W      = 11,
  parameter int TOL        = 2,
  parameter int DIV_NARROW = 8,
  parameter int DIV_WIDE   = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ws,
  input  logic       ext_bclk,
  output logic       bclk_en,
  output logic [1:0] ratio_code,
  output logic       locked,
  output logic       invalid,
  output logic [4:0] word_bits
);

  logic             ws_toggle;
  logic [CNT_W-1:0] period;
  logic             period_vld;
  ratio_e           cls;
  logic             cls_vld;
  ratio_e           lock_ratio;

  osr_ws_meter #(.CNT_W(CNT_W)) u_meter (
    .clk        (clk),
    .rst        (rst),
    .ws         (ws),
    .ws_toggle  (ws_toggle),
    .period     (period),
    .period_vld (period_vld)
  );

  osr_ratio_classifier #(.CNT_W(CNT_W), .TOL(TOL)) u_class (
    .clk        (clk),
    .rst        (rst),
    .period     (period),
    .period_vld (period_vld),
    .cls        (cls),
    .cls_vld    (cls_vld)
  );

  osr_lock_fsm u_lock (
    .clk        (clk),
    .rst        (rst),
    .cls        (cls),
    .cls_vld    (cls_vld),
    .locked     (locked),
    .invalid    (invalid),
    .lock_ratio (lock_ratio)
  );

  osr_bclk_div #(.DIV_NARROW(DIV_NARROW), .DIV_WIDE(DIV_WIDE)) u_div (
    .clk       (clk),
    .rst       (rst),
    .ws_toggle (ws_toggle),
    .run       (locked && !ext_bclk),
    .wide      (lock_ratio == RATIO_512),
    .bclk_en   (bclk_en)
  );

  assign ratio_code = lock_ratio;

  always_ff @(posedge clk) begin
    if (rst)                          word_bits <= WORD_NONE;
    else if (ext_bclk)                word_bits <= WORD_LONG;
    else if (!locked)                 word_bits <= WORD_NONE;
    else if (lock_ratio == RATIO_384) word_bits <= WORD_LONG;
    else                              word_bits <= WORD_SHORT;
  end

endmodule

// File: rtl/osr_clock_detect_chk.sv
`timescale 1ns/1ps
module osr_clock_detect_chk (
  input logic       clk,
  input logic       rst,
  input logic       ext_bclk,
  input logic       bclk_en,
  input logic [1:0] ratio_code,
  input logic       locked,
  input logic       invalid,
  input logic [4:0] word_bits
);

  AST_LOCK_HAS_RATIO: assert property (@(posedge clk) disable iff (rst) locked |-> ratio_code != 2'd0); // R2
  AST_UNLOCK_NO_RATIO: assert property (@(posedge clk) disable iff (rst) !locked |-> ratio_code == 2'd0); // R2
  AST_LOCK_ON_VALID: assert property (@(posedge clk) disable iff (rst) $rose(locked) |-> !invalid); // R4
  AST_UNLOCKED_NO_BCLK: assert property (@(posedge clk) disable iff (rst) !locked |=> !bclk_en); // R6
  AST_BCLK_SINGLE: assert property (@(posedge clk) disable iff (rst) bclk_en |=> !bclk_en); // R6
  AST_EXT_NO_BCLK: assert property (@(posedge clk) disable iff (rst) ext_bclk |=> !bclk_en); // R9
  AST_EXT_WORD_LONG: assert property (@(posedge clk) disable iff (rst) ext_bclk |=> word_bits == 5'd24); // R7
  AST_WORD_384: assert property (@(posedge clk) disable iff (rst) (!ext_bclk && locked && ratio_code == 2'd2) |=> word_bits == 5'd24); // R7

endmodule

bind osr_clock_detect osr_clock_detect_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .ext_bclk   (ext_bclk),
  .bclk_en    (bclk_en),
  .ratio_code (ratio_code),
  .locked     (locked),
  .invalid    (invalid),
  .word_bits  (word_bits)
);

// File: tb/osr_clock_detect_test.sv
`timescale 1ns/1ps
module osr_clock_detect_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       ws;
  logic       ext_bclk;
  logic       bclk_en;
  logic [1:0] ratio_code;
  logic       locked;
  logic       invalid;
  logic [4:0] word_bits;

  int   n_chk  = 0;
  int   n_fail = 0;
  int   pulses;
  logic prev_lk;
  logic drop_seen;
  logic drop_inv;

  always #5 clk = ~clk;

  osr_clock_detect uut (
    .clk        (clk),
    .rst        (rst),
    .ws         (ws),
    .ext_bclk   (ext_bclk),
    .bclk_en    (bclk_en),
    .ratio_code (ratio_code),
    .locked     (locked),
    .invalid    (invalid),
    .word_bits  (word_bits)
  );

  // {ext, period, code, locked, invalid, pulses (255 = skip), word_bits}
  localparam int NV = 14;
  localparam logic [33:0] VEC [NV] = '{
    {1'b0, 16'd256,  2'd1, 1'b1, 1'b0, 8'd32,  5'd16},
    {1'b0, 16'd384,  2'd2, 1'b1, 1'b0, 8'd48,  5'd24},
    {1'b0, 16'd512,  2'd3, 1'b1, 1'b0, 8'd32,  5'd16},
    {1'b0, 16'd258,  2'd1, 1'b1, 1'b0, 8'd255, 5'd16},
    {1'b0, 16'd254,  2'd1, 1'b1, 1'b0, 8'd255, 5'd16},
    {1'b0, 16'd386,  2'd2, 1'b1, 1'b0, 8'd255, 5'd24},
    {1'b0, 16'd510,  2'd3, 1'b1, 1'b0, 8'd255, 5'd16},
    {1'b0, 16'd259,  2'd0, 1'b0, 1'b1, 8'd0,   5'd0},
    {1'b0, 16'd381,  2'd0, 1'b0, 1'b1, 8'd0,   5'd0},
    {1'b0, 16'd300,  2'd0, 1'b0, 1'b1, 8'd0,   5'd0},
    {1'b0, 16'd2304, 2'd0, 1'b0, 1'b1, 8'd0,   5'd0},
    {1'b1, 16'd384,  2'd2, 1'b1, 1'b0, 8'd0,   5'd24},
    {1'b1, 16'd256,  2'd1, 1'b1, 1'b0, 8'd0,   5'd24},
    {1'b1, 16'd300,  2'd0, 1'b0, 1'b1, 8'd0,   5'd24}
  };

  task automatic chk(string req, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    ws  = 1'b0;
    repeat (3) @(negedge clk);
    rst     = 1'b0;
    prev_lk = 1'b0;
  endtask

  // one word-select period starting with its rising edge; counts enables
  task automatic drive_period(int len);
    pulses = 0;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if (bclk_en) pulses++;
      if (prev_lk && !locked) begin
        drop_seen = 1'b1;
        drop_inv  = invalid;
      end
      prev_lk = locked;
      ws = (k < len - len / 2);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; ws = 1'b0; ext_bclk = 1'b0;
    prev_lk = 1'b0; drop_seen = 1'b0; drop_inv = 1'b0; pulses = 0;
    repeat (2) @(negedge clk);

    // reset state
    do_reset();
    chk("R2", "reset ratio_code", ratio_code, 0);
    chk("R4", "reset locked", locked, 0);
    chk("R3", "reset invalid", invalid, 0);
    chk("R6", "reset bclk_en", bclk_en, 0);
    chk("R7", "reset word_bits", word_bits, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [33:0] v;
      v = VEC[i];
      ext_bclk = v[33];
      do_reset();
      repeat (4) drive_period(int'(v[32:17]));
      chk("R2", $sformatf("vec%0d ratio_code", i), ratio_code, int'(v[16:15]));
      chk("R4", $sformatf("vec%0d locked", i), locked, int'(v[14]));
      chk("R3", $sformatf("vec%0d invalid", i), invalid, int'(v[13]));
      chk("R7", $sformatf("vec%0d word_bits", i), word_bits, int'(v[4:0]));
      drive_period(int'(v[32:17]));
      if (v[12:5] != 8'd255) begin
        if (v[33]) chk("R9", $sformatf("vec%0d pulses ext", i), pulses, int'(v[12:5]));
        else       chk("R6", $sformatf("vec%0d pulses", i), pulses, int'(v[12:5]));
      end
      if (v[32:17] == 16'd2304) chk("R8", "saturated period not aliased", ratio_code, 0);
    end

    // first edge after reset gives no measurement; lock needs two
    ext_bclk = 1'b0;
    do_reset();
    drive_period(256);
    chk("R1", "first edge no measurement invalid", invalid, 0);
    drive_period(256);
    chk("R4", "one measurement not locked", locked, 0);
    drive_period(256);
    chk("R4", "two measurements locked", locked, 1);
    chk("R2", "locked ratio 256", ratio_code, 1);

    // single miss tolerated
    drive_period(384); drive_period(256); drive_period(256);
    chk("R5", "single miss keeps lock", locked, 1);
    chk("R5", "single miss keeps ratio", ratio_code, 1);

    // two misses drop lock, then restart
    drive_period(384); drive_period(384); drive_period(256);
    chk("R5", "two misses drop lock", locked, 0);
    chk("R5", "dropped ratio_code", ratio_code, 0);
    drive_period(256);
    chk("R5", "restart needs two", locked, 0);
    drive_period(256);
    chk("R5", "relocked", locked, 1);

    // invalid raised in the same cycle lock falls
    drop_seen = 1'b0; drop_inv = 1'b0;
    drive_period(300); drive_period(300);
    chk("R3", "first bad period flags invalid", invalid, 1);
    chk("R5", "first bad period keeps lock", locked, 1);
    drive_period(256);
    chk("R5", "second bad period drops lock", locked, 0);
    chk("R3", "invalid held at drop", invalid, 1);
    chk("R5", "drop observed", drop_seen, 1);
    chk("R3", "invalid in drop cycle", drop_inv, 1);
    drive_period(256);
    chk("R3", "valid period clears invalid", invalid, 0);

    // external bit clock mode mid-run
    drive_period(256);
    chk("R4", "relock before ext", locked, 1);
    ext_bclk = 1'b1;
    drive_period(256);
    chk("R9", "ext no pulses", pulses, 0);
    chk("R9", "ext keeps lock", locked, 1);
    chk("R7", "ext word_bits", word_bits, 24);
    ext_bclk = 1'b0;
    drive_period(256);
    drive_period(256);
    chk("R6", "internal pulses resume", pulses, 32);
    chk("R7", "internal word_bits 256", word_bits, 16);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule